// File: doc/BRIEF.md
# IPv4 Transmit Frame Builder

This block turns a single request to send an IPv4 datagram into a byte stream for an Ethernet MAC. The caller pulses a start strobe with a protocol number, a payload length and a destination IP address. For a unicast destination the block asks an external address-lookup unit for the next-hop MAC address. For the limited-broadcast destination it skips the lookup and uses the all-ones MAC address. It then requests the shared MAC transmit channel and holds that request for the whole frame.

Once the channel is granted, the block emits one byte per accepted cycle. It sends a 14-byte Ethernet header, then a 20-byte IPv4 header with a computed checksum, then the caller's payload. The payload passes straight through under the MAC's backpressure. The first and last bytes of the frame carry marker flags. A two-bit result code reports whether the block is idle, sending, done, or stopped by a failed lookup.

Top module: `ipv4_tx_builder`

## Requirements
- R1: A one-cycle `start` pulse in idle latches `proto`, `pay_len` and `dst_ip`. On the next cycle `result` changes from 0 (none) to 1 (sending).
- R2: For a destination other than 255.255.255.255, `lkp_req` is high from the cycle after start, with `lkp_ip` equal to the destination. It goes low on the cycle after `lkp_ok` is seen.
- R3: For destination 255.255.255.255, `lkp_req` never rises, `chan_req` rises on the cycle after start, and the frame's first six bytes are 0xFF.
- R4: `chan_req` rises as soon as the destination MAC is known and stays high through the frame. It is low on the cycle after the byte flagged last is accepted.
- R5: `out_valid` is high only while `chan_grant` and `mac_ready` are both high. `out_first` is set on exactly one byte, the first byte of the frame.
- R6: The frame starts with bytes 0..5 = destination MAC, bytes 6..11 = `local_mac` and bytes 12..13 = 0x0800. An IPv4 header follows at bytes 14..33: 0x45, 0x00, total length = payload length + 20, identification 0, flags/fragment 0, TTL = parameter `TTL_VAL`, protocol, checksum, source = `local_ip`, destination. All multi-byte fields are sent most significant byte first.
- R7: Frame bytes 24..25 hold the ones-complement of the ones-complement sum of the ten 16-bit header words, summed with the checksum word taken as zero.
- R8: `pay_ready` is high only after all 34 header bytes are sent and only while `mac_ready` and `chan_grant` are high. It follows `mac_ready` in the same cycle.
- R9: A payload byte is forwarded only in a cycle where `pay_valid` and `pay_ready` are both high. Cycles with `pay_valid` low insert gaps without losing or duplicating bytes.
- R10: The forwarded byte that carries `pay_last` has `out_last` set. On the next cycle `result` is 2 (sent).
- R11: If `lkp_err` arrives while the lookup is pending, `result` becomes 3 (error), `chan_req` never rises and the block returns to idle, ready for a new start.
- R12: While reset is held and right after it, `lkp_req`, `chan_req`, `out_valid`, `out_last` and `pay_ready` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a datagram |
| proto | input | 8 | IP protocol number of the request |
| pay_len | input | 16 | Payload length in bytes |
| dst_ip | input | 32 | Destination IP address |
| local_ip | input | 32 | Source IP address placed in the header |
| local_mac | input | 48 | Source MAC address placed in the header |
| result | output | 2 | 0 none, 1 sending, 2 sent, 3 error |
| lkp_req | output | 1 | Address-lookup request |
| lkp_ip | output | 32 | IP address to resolve |
| lkp_ok | input | 1 | Lookup produced a MAC address |
| lkp_err | input | 1 | Lookup failed |
| lkp_mac | input | 48 | MAC address returned by the lookup |
| chan_req | output | 1 | Request for the MAC transmit channel |
| chan_grant | input | 1 | Channel granted |
| mac_ready | input | 1 | MAC accepts a byte this cycle |
| out_valid | output | 1 | Output byte is valid |
| out_first | output | 1 | Output byte is the first of the frame |
| out_last | output | 1 | Output byte is the last of the frame |
| out_data | output | 8 | Output byte |
| pay_ready | output | 1 | Block accepts a payload byte this cycle |
| pay_valid | input | 1 | Payload byte is valid |
| pay_last | input | 1 | Payload byte is the final one |
| pay_data | input | 8 | Payload byte |

## Verification
The bench builds the block with `TTL_VAL` set to 64 instead of the default 128. A header byte that stayed fixed at 128 would then be caught, and the checksum is tested against a TTL word that the default does not produce. Payload lengths of 1, 3, 4, 8 and 20 bytes are used. With these short frames, each ready and valid mask walks both the header and the payload within a few cycles, so stalls land on the header/payload boundary and on the final byte. A failed lookup followed by a fresh request shows that the error path returns cleanly to idle.

// File: rtl/ipv4tx_pkg.sv
package ipv4tx_pkg;
    localparam int BYTE_W        = 8;
    localparam int MAC_W         = 48;
    localparam int IP_W          = 32;
    localparam int LEN_W         = 16;
    localparam int ETH_HDR_BYTES = 14;
    localparam int IP_HDR_BYTES  = 20;
    localparam int HDR_BYTES     = ETH_HDR_BYTES + IP_HDR_BYTES;
    localparam int IP_WORDS      = IP_HDR_BYTES / 2;
    localparam int IDX_W         = $clog2(HDR_BYTES);

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_SENDING = 2'd1,
        RES_SENT    = 2'd2,
        RES_ERROR   = 2'd3
    } tx_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_CHAN,
        ST_HDR,
        ST_PAY
    } tx_state_e;

    typedef struct packed {
        tx_state_e               st;
        tx_result_e              res;
        logic [BYTE_W-1:0]       proto;
        logic [LEN_W-1:0]        len;
        logic [IP_W-1:0]         dip;
        logic [MAC_W-1:0]        dmac;
        logic [IDX_W-1:0]        idx;
    } ctl_regs_t;
endpackage

// File: rtl/ipv4tx_csum.sv
module ipv4tx_csum #(
    parameter int WORDS = 10
) (
    input  logic [WORDS*16-1:0] words_i,
    output logic [15:0]         csum_o
);
    localparam int ACC_W = 16 + $clog2(WORDS) + 1;

    logic [ACC_W-1:0] acc;
    logic [16:0]      fold1;
    logic [16:0]      fold2;

    always_comb begin
        acc = '0;
        for (int w = 0; w < WORDS; w++) begin
            acc = acc + ACC_W'(words_i[w*16 +: 16]);
        end
        fold1  = 17'(acc[15:0]) + 17'(acc[ACC_W-1:16]);
        fold2  = 17'(fold1[15:0]) + 17'(fold1[16]);
        csum_o = ~fold2[15:0];
    end
endmodule

// File: rtl/ipv4tx_hdr.sv
module ipv4tx_hdr
    import ipv4tx_pkg::*;
#(
    parameter logic [7:0]  TTL_VAL   = 8'd128,
    parameter logic [15:0] ETHERTYPE = 16'h0800
) (
    input  logic [MAC_W-1:0]  dmac_i,
    input  logic [MAC_W-1:0]  smac_i,
    input  logic [IP_W-1:0]   sip_i,
    input  logic [IP_W-1:0]   dip_i,
    input  logic [BYTE_W-1:0] proto_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [LEN_W-1:0]          tot_len;
    logic [IP_WORDS*16-1:0]    words;
    logic [15:0]               csum;
    logic [HDR_BYTES*8-1:0]    hdr_vec;
    logic [BYTE_W-1:0]         hdr_bytes [HDR_BYTES];

    assign tot_len = len_i + LEN_W'(IP_HDR_BYTES);

    // checksum word slot (word 5) is zero while summing
    assign words = {16'h4500, tot_len, 16'h0000, 16'h0000,
                    TTL_VAL, proto_i, 16'h0000,
                    sip_i, dip_i};

    ipv4tx_csum #(.WORDS(IP_WORDS)) u_csum (
        .words_i (words),
        .csum_o  (csum)
    );

    assign hdr_vec = {dmac_i, smac_i, ETHERTYPE,
                      8'h45, 8'h00, tot_len, 16'h0000, 16'h0000,
                      TTL_VAL, proto_i, csum, sip_i, dip_i};

    for (genvar gi = 0; gi < HDR_BYTES; gi++) begin : g_split
        assign hdr_bytes[gi] = hdr_vec[(HDR_BYTES-1-gi)*8 +: 8];
    end

    always_comb begin
        byte_o = '0;
        if (int'(idx_i) < HDR_BYTES) begin
            byte_o = hdr_bytes[idx_i];
        end
    end
endmodule

// File: rtl/ipv4tx_ctl.sv
module ipv4tx_ctl
    import ipv4tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] proto,
    input  logic [LEN_W-1:0]  pay_len,
    input  logic [IP_W-1:0]   dst_ip,
    input  logic              lkp_ok,
    input  logic              lkp_err,
    input  logic [MAC_W-1:0]  lkp_mac,
    input  logic              chan_grant,
    input  logic              mac_ready,
    input  logic              pay_valid,
    input  logic              pay_last,
    output tx_result_e        result,
    output logic              lkp_req,
    output logic              chan_req,
    output logic              hdr_fire,
    output logic              pay_ready,
    output logic              pay_fire,
    output logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] lat_proto,
    output logic [LEN_W-1:0]  lat_len,
    output logic [IP_W-1:0]   lat_dip,
    output logic [MAC_W-1:0]  lat_dmac
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

    ctl_regs_t q, d;

    assign result    = q.res;
    assign lkp_req   = (q.st == ST_LOOKUP);
    assign chan_req  = (q.st == ST_CHAN) || (q.st == ST_HDR) || (q.st == ST_PAY);
    assign hdr_fire  = (q.st == ST_HDR) && chan_grant && mac_ready;
    assign pay_ready = (q.st == ST_PAY) && chan_grant && mac_ready;
    assign pay_fire  = pay_ready && pay_valid;
    assign idx       = q.idx;
    assign lat_proto = q.proto;
    assign lat_len   = q.len;
    assign lat_dip   = q.dip;
    assign lat_dmac  = q.dmac;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.proto = proto;
                    d.len   = pay_len;
                    d.dip   = dst_ip;
                    d.idx   = '0;
                    d.res   = RES_SENDING;
                    if (dst_ip == '1) begin
                        d.dmac = '1;
                        d.st   = ST_CHAN;
                    end else begin
                        d.st = ST_LOOKUP;
                    end
                end
            end
            ST_LOOKUP: begin
                if (lkp_ok) begin
                    d.dmac = lkp_mac;
                    d.st   = ST_CHAN;
                end else if (lkp_err) begin
                    d.res = RES_ERROR;
                    d.st  = ST_IDLE;
                end
            end
            ST_CHAN: begin
                if (chan_grant) begin
                    d.st = ST_HDR;
                end
            end
            ST_HDR: begin
                if (hdr_fire) begin
                    if (q.idx == LAST_IDX) begin
                        d.idx = '0;
                        d.st  = ST_PAY;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            ST_PAY: begin
                if (pay_fire && pay_last) begin
                    d.res = RES_SENT;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st    <= ST_IDLE;
            q.res   <= RES_NONE;
            q.proto <= '0;
            q.len   <= '0;
            q.dip   <= '0;
            q.dmac  <= '0;
            q.idx   <= '0;
        end else begin
            q <= d;
        end
    end

    // R1
    start_sending_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE && start) |=> (result == RES_SENDING));

    // R3
    bcast_nolookup_chk: assert property (@(posedge clk) disable iff (rst)
        lkp_req |-> (lat_dip != '1));

    // R8
    pay_ready_chk: assert property (@(posedge clk) disable iff (rst)
        pay_ready |-> (mac_ready && chan_grant));

    // R11
    err_nochan_chk: assert property (@(posedge clk) disable iff (rst)
        (lkp_req && lkp_err && !lkp_ok) |=> (!chan_req && result == RES_ERROR));
endmodule

// File: rtl/ipv4_tx_builder.sv
module ipv4_tx_builder
    import ipv4tx_pkg::*;
#(
    parameter logic [7:0] TTL_VAL = 8'd128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  proto,
    input  logic [15:0] pay_len,
    input  logic [31:0] dst_ip,
    input  logic [31:0] local_ip,
    input  logic [47:0] local_mac,
    output logic [1:0]  result,
    output logic        lkp_req,
    output logic [31:0] lkp_ip,
    input  logic        lkp_ok,
    input  logic        lkp_err,
    input  logic [47:0] lkp_mac,
    output logic        chan_req,
    input  logic        chan_grant,
    input  logic        mac_ready,
    output logic        out_valid,
    output logic        out_first,
    output logic        out_last,
    output logic [7:0]  out_data,
    output logic        pay_ready,
    input  logic        pay_valid,
    input  logic        pay_last,
    input  logic [7:0]  pay_data
);
    tx_result_e        res;
    logic              hdr_fire;
    logic              pay_fire;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] lat_proto;
    logic [LEN_W-1:0]  lat_len;
    logic [IP_W-1:0]   lat_dip;
    logic [MAC_W-1:0]  lat_dmac;
    logic [BYTE_W-1:0] hdr_byte;

    ipv4tx_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .proto      (proto),
        .pay_len    (pay_len),
        .dst_ip     (dst_ip),
        .lkp_ok     (lkp_ok),
        .lkp_err    (lkp_err),
        .lkp_mac    (lkp_mac),
        .chan_grant (chan_grant),
        .mac_ready  (mac_ready),
        .pay_valid  (pay_valid),
        .pay_last   (pay_last),
        .result     (res),
        .lkp_req    (lkp_req),
        .chan_req   (chan_req),
        .hdr_fire   (hdr_fire),
        .pay_ready  (pay_ready),
        .pay_fire   (pay_fire),
        .idx        (idx),
        .lat_proto  (lat_proto),
        .lat_len    (lat_len),
        .lat_dip    (lat_dip),
        .lat_dmac   (lat_dmac)
    );

    ipv4tx_hdr #(.TTL_VAL(TTL_VAL)) u_hdr (
        .dmac_i  (lat_dmac),
        .smac_i  (local_mac),
        .sip_i   (local_ip),
        .dip_i   (lat_dip),
        .proto_i (lat_proto),
        .len_i   (lat_len),
        .idx_i   (idx),
        .byte_o  (hdr_byte)
    );

    assign result    = res;
    assign lkp_ip    = lat_dip;
    assign out_valid = hdr_fire || pay_fire;
    assign out_first = hdr_fire && (idx == '0);
    assign out_last  = pay_fire && pay_last;
    assign out_data  = hdr_fire ? hdr_byte : pay_data;

    // R5
    valid_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (chan_grant && mac_ready));

    // R4
    chan_release_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |=> !chan_req);

    // R4
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_req && !(out_valid && out_last)) |=> chan_req);

    // R5
    first_once_chk: assert property (@(posedge clk) disable iff (rst)
        out_first |-> (out_valid && !out_last));
endmodule

// File: tb/sim_ipv4_tx_builder.sv
module sim_ipv4_tx_builder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  proto = '0;
    logic [15:0] pay_len = '0;
    logic [31:0] dst_ip = '0;
    logic [31:0] local_ip = 32'hC0A8_0109;
    logic [47:0] local_mac = 48'h02_11_22_33_44_55;
    logic [1:0]  result;
    logic        lkp_req;
    logic [31:0] lkp_ip;
    logic        lkp_ok = 1'b0;
    logic        lkp_err = 1'b0;
    logic [47:0] lkp_mac = '0;
    logic        chan_req;
    logic        chan_grant = 1'b0;
    logic        mac_ready = 1'b0;
    logic        out_valid, out_first, out_last;
    logic [7:0]  out_data;
    logic        pay_ready;
    logic        pay_valid = 1'b0;
    logic        pay_last = 1'b0;
    logic [7:0]  pay_data = '0;

    localparam logic [7:0] BENCH_TTL = 8'd64;

    ipv4_tx_builder #(.TTL_VAL(BENCH_TTL)) u0 (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // capture of the output stream, sampled mid-cycle
    logic [7:0] cap [0:127];
    int  cap_n = 0, first_cnt = 0, last_cnt = 0, first_pos = -1, last_pos = -1;
    bit  cap_en = 0;
    always @(negedge clk) begin
        if (cap_en && out_valid && cap_n < 128) begin
            cap[cap_n] = out_data;
            if (out_first) begin first_cnt++; first_pos = cap_n; end
            if (out_last)  begin last_cnt++;  last_pos  = cap_n; end
            cap_n++;
        end
    end

    typedef struct packed {
        logic [7:0]  proto;
        logic [15:0] len;
        logic [31:0] dst;
        logic [47:0] mac;
        logic [3:0]  delay;
        logic        err;
        logic [7:0]  gap;
        logic [7:0]  bp;
    } vec_t;

    localparam vec_t TBL [0:4] = '{
        '{8'h11, 16'd8,  32'hC0A8_0A05, 48'h0A_1B_2C_3D_4E_5F, 4'd3, 1'b0, 8'b1101_1011, 8'b1110_1111},
        '{8'h06, 16'd1,  32'hFFFF_FFFF, 48'h0,                 4'd0, 1'b0, 8'b1111_1111, 8'b1111_1111},
        '{8'h01, 16'd20, 32'h0A00_0001, 48'h00_AA_BB_CC_DD_EE, 4'd0, 1'b0, 8'b1111_1111, 8'b1011_0111},
        '{8'h11, 16'd4,  32'h0A00_0002, 48'h0,                 4'd2, 1'b1, 8'b1111_1111, 8'b1111_1111},
        '{8'h35, 16'd3,  32'h0102_0304, 48'h12_34_56_78_9A_BC, 4'd1, 1'b0, 8'b0101_0101, 8'b1100_1111}
    };

    logic [7:0] exp_b [0:127];

    function automatic logic [15:0] ref_csum(input logic [7:0] pr, input logic [15:0] tl,
                                             input logic [31:0] s, input logic [31:0] dd);
        logic [31:0] sum;
        sum = 32'h4500 + 32'(tl) + 32'({BENCH_TTL, pr}) +
              32'(s[31:16]) + 32'(s[15:0]) + 32'(dd[31:16]) + 32'(dd[15:0]);
        while (sum[31:16] != 0) sum = 32'(sum[15:0]) + 32'(sum[31:16]);
        return ~sum[15:0];
    endfunction

    task automatic build_exp(input vec_t v);
        logic [47:0] dm;
        logic [15:0] tl, cs;
        dm = (v.dst == 32'hFFFF_FFFF) ? 48'hFFFF_FFFF_FFFF : v.mac;
        tl = v.len + 16'd20;
        cs = ref_csum(v.proto, tl, local_ip, v.dst);
        for (int i = 0; i < 6; i++) begin
            exp_b[i]     = dm[47-8*i -: 8];
            exp_b[6 + i] = local_mac[47-8*i -: 8];
        end
        exp_b[12] = 8'h08; exp_b[13] = 8'h00;
        exp_b[14] = 8'h45; exp_b[15] = 8'h00;
        exp_b[16] = tl[15:8]; exp_b[17] = tl[7:0];
        exp_b[18] = 8'h00; exp_b[19] = 8'h00; exp_b[20] = 8'h00; exp_b[21] = 8'h00;
        exp_b[22] = BENCH_TTL; exp_b[23] = v.proto;
        exp_b[24] = cs[15:8]; exp_b[25] = cs[7:0];
        for (int i = 0; i < 4; i++) begin
            exp_b[26 + i] = local_ip[31-8*i -: 8];
            exp_b[30 + i] = v.dst[31-8*i -: 8];
        end
        for (int k = 0; k < int'(v.len); k++) exp_b[34 + k] = 8'h30 + 8'(k);
    endtask

    task automatic run_frame(input vec_t v);
        bit bcast;
        int k, cyc, hdr_bad, pay_bad;
        bit done, r8_done;
        cap_n = 0; first_cnt = 0; last_cnt = 0; first_pos = -1; last_pos = -1;
        cap_en = 1;
        bcast = (v.dst == 32'hFFFF_FFFF);
        @(posedge clk); #2;
        proto = v.proto; pay_len = v.len; dst_ip = v.dst; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        @(negedge clk);
        chk(result == 2'd1, "R1", "result after start", 64'(result), 64'd1);
        if (bcast) begin
            chk(lkp_req == 1'b0, "R3", "lookup on broadcast", 64'(lkp_req), 64'd0);
            chk(chan_req == 1'b1, "R3", "chan_req on broadcast", 64'(chan_req), 64'd1);
        end else begin
            chk(lkp_req == 1'b1, "R2", "lookup raised", 64'(lkp_req), 64'd1);
            chk(lkp_ip == v.dst, "R2", "lookup address", 64'(lkp_ip), 64'(v.dst));
            repeat (int'(v.delay)) @(posedge clk);
            @(posedge clk); #2;
            if (v.err) lkp_err = 1'b1;
            else begin lkp_ok = 1'b1; lkp_mac = v.mac; end
            @(posedge clk); #2;
            lkp_ok = 1'b0; lkp_err = 1'b0; lkp_mac = '0;
            @(negedge clk);
            chk(lkp_req == 1'b0, "R2", "lookup dropped", 64'(lkp_req), 64'd0);
            if (v.err) begin
                chk(result == 2'd3, "R11", "error result", 64'(result), 64'd3);
                for (int c = 0; c < 3; c++) begin
                    @(negedge clk);
                    chk(chan_req == 1'b0 && out_valid == 1'b0, "R11", "no channel after error",
                        64'({chan_req, out_valid}), 64'd0);
                end
                cap_en = 0;
                return;
            end
            chk(chan_req == 1'b1, "R4", "chan_req after mac known", 64'(chan_req), 64'd1);
        end
        chk(out_valid == 1'b0, "R5", "valid before grant", 64'(out_valid), 64'd0);
        @(posedge clk); #2;
        mac_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R5", "valid with ready but no grant", 64'(out_valid), 64'd0);
        @(posedge clk); #2;
        chan_grant = 1'b1;
        k = 0; cyc = 0; done = 0; r8_done = 0;
        while (!done && cyc < 400) begin
            mac_ready = v.bp[cyc % 8];
            #1;
            if (pay_ready && v.gap[cyc % 8]) begin
                pay_valid = 1'b1; pay_data = 8'h30 + 8'(k);
                pay_last = (k == int'(v.len) - 1);
            end else begin
                pay_valid = 1'b0; pay_last = 1'b0;
            end
            @(negedge clk);
            if (!r8_done && cap_n >= 34 && !mac_ready) begin
                r8_done = 1;
                chk(pay_ready == 1'b0, "R8", "pay_ready with MAC stalled", 64'(pay_ready), 64'd0);
            end
            if (pay_valid && pay_ready) begin
                k++;
                if (k == int'(v.len)) done = 1;
            end
            @(posedge clk); #2;
            cyc++;
        end
        pay_valid = 1'b0; pay_last = 1'b0;
        @(negedge clk);
        chk(chan_req == 1'b0, "R4", "chan_req after last byte", 64'(chan_req), 64'd0);
        chk(result == 2'd2, "R10", "sent result", 64'(result), 64'd2);
        chan_grant = 1'b0; mac_ready = 1'b0; cap_en = 0;
        build_exp(v);
        chk(cap_n == 34 + int'(v.len), "R9", "frame byte count", 64'(cap_n), 64'(34 + int'(v.len)));
        hdr_bad = 0; pay_bad = 0;
        for (int i = 0; i < 34; i++) begin
            if (i == 24 || i == 25) continue;
            if (cap[i] !== exp_b[i]) hdr_bad++;
        end
        chk(hdr_bad == 0, bcast ? "R3" : "R6", "header bytes mismatching", 64'(hdr_bad), 64'd0);
        chk({cap[24], cap[25]} == {exp_b[24], exp_b[25]}, "R7", "header checksum",
            64'({cap[24], cap[25]}), 64'({exp_b[24], exp_b[25]}));
        for (int i = 34; i < cap_n && i < 128; i++) if (cap[i] !== exp_b[i]) pay_bad++;
        chk(pay_bad == 0, "R9", "payload bytes mismatching", 64'(pay_bad), 64'd0);
        chk(first_cnt == 1 && first_pos == 0, "R5", "first flag position",
            64'(first_pos), 64'd0);
        chk(last_cnt == 1 && last_pos == cap_n - 1, "R10", "last flag position",
            64'(last_pos), 64'(cap_n - 1));
    endtask

    bit finished = 0;

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({lkp_req, chan_req, out_valid, out_last, pay_ready} == 5'b0 && result == 2'd0,
            "R12", "outputs in reset", 64'({lkp_req, chan_req, out_valid, out_last, pay_ready, result}), 64'd0);
        @(posedge clk); #2;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk({lkp_req, chan_req, out_valid, out_last, pay_ready} == 5'b0 && result == 2'd0,
            "R12", "outputs after reset", 64'({lkp_req, chan_req, out_valid, out_last, pay_ready, result}), 64'd0);

        for (int t = 0; t < 5; t++) begin
            run_frame(TBL[t]);
            repeat (2) @(posedge clk);
        end

        // directed: reset mid-frame returns everything to idle (R12)
        @(posedge clk); #2;
        proto = 8'h11; pay_len = 16'd2; dst_ip = 32'hFFFF_FFFF; start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0; chan_grant = 1'b1; mac_ready = 1'b1;
        repeat (3) @(posedge clk); #2;
        rst = 1'b1;
        @(posedge clk); #2;
        rst = 1'b0; chan_grant = 1'b0; mac_ready = 1'b0;
        @(negedge clk);
        chk({lkp_req, chan_req, out_valid, out_last, pay_ready} == 5'b0 && result == 2'd0,
            "R12", "outputs after mid-frame reset",
            64'({lkp_req, chan_req, out_valid, out_last, pay_ready, result}), 64'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1ms;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule